// File: doc/BRIEF.md
# DDR2 DLL-State Command Guard

This block sits between a memory controller's command scheduler and the command bus of a DDR2 device. It watches every command that leaves it and keeps track of the state of the device's delay-locked loop: whether the loop is switched on, whether it has been reset since it was last switched on, and how many clocks have passed since that reset. READ commands are held back with a ready/stall handshake until the lock window after the latest DLL reset or self-refresh exit has elapsed. The scheduler keeps the blocked READ on its interface, and every command behind it waits, so command order is preserved.

When the DLL is off and the board signals that the memory clock is slow, each AUTO REFRESH that leaves the block is followed on the very next slot by an inserted PRECHARGE ALL. The scheduler is stalled for that slot. The block also decodes writes to the extended mode register into status flags for the data strobes, output enable and drive strength. The read-strobe flags are only reported for the x8 device organisation.

Top module: `ddr2_dll_guard`

## Requirements
- R1: After reset, `dll_enabled`=1, `dll_locked`=0, `dqs_n_en`=1, `rdqs_en`=0, `rdqs_n_en`=0, `outputs_en`=1 and `drive_reduced`=0. A READ is stalled until a DLL reset has been issued and its window has run out.
- R2: Command codes on `up_cmd`/`dn_cmd` are NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4, AUTO REFRESH=5, SELF REFRESH entry=6, SELF REFRESH exit=7, MODE LOAD=8. A MODE LOAD with bank 1 writes the extended mode register. In that register, address bit 0 = 1 turns the DLL off (`dll_enabled`=0, `dll_locked`=0) and bit 0 = 0 turns it on. Turning the DLL on from off leaves `dll_locked`=0 until a new DLL reset has completed.
- R3: A MODE LOAD with bank 0 and address bit 8 = 1 resets the DLL. While the DLL is on, no READ leaves the block until LOCK_CYCLES clock edges after the edge that issued the reset. The edge that issues the READ is counted. A READ presented in the cycle right after the reset is stalled for LOCK_CYCLES-1 cycles and then passes, with `up_ready`=0 and `dn_valid`=0 while it is stalled.
- R4: SELF REFRESH entry sets `dll_enabled`=0 and `dll_locked`=0. SELF REFRESH exit sets `dll_enabled`=1, keeps `dll_locked`=0 and restarts the R3 window.
- R5: An AUTO REFRESH issued while `dll_enabled`=0 and `slow_mode`=1 is followed in the next cycle by `dn_valid`=1, `dn_cmd`=PRECHARGE, `dn_addr` bit 10 = 1 and `dn_ba`=0.
- R6: During the inserted PRECHARGE ALL cycle `up_ready`=0. An AUTO REFRESH issued with `slow_mode`=0 or with the DLL on causes no insertion: the next cycle shows `dn_valid`=0 and `up_ready`=1 when the scheduler is idle.
- R7: Extended-register bit 10 = 1 clears `dqs_n_en`. Bit 11 = 1 sets `rdqs_en`. `rdqs_n_en` is 1 only when bit 11 = 1 and bit 10 = 0.
- R8: When DEV_WIDTH is not 8, `rdqs_en` and `rdqs_n_en` stay 0 whatever is written.
- R9: Extended-register bit 12 = 1 clears `outputs_en`. Bit 1 = 1 sets `drive_reduced`.
- R10: While the DLL is off, a READ passes with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_mode | input | 1 | Strap: memory clock is below the slow threshold |
| up_valid | input | 1 | Scheduler command valid |
| up_cmd | input | 4 | Scheduler command code |
| up_ba | input | BA_W | Scheduler bank address |
| up_addr | input | ADDR_W | Scheduler row/column/mode address |
| up_ready | output | 1 | Block accepts the scheduler command this cycle |
| dn_valid | output | 1 | Command issued to the device this cycle |
| dn_cmd | output | 4 | Issued command code |
| dn_ba | output | BA_W | Issued bank address |
| dn_addr | output | ADDR_W | Issued address |
| dll_enabled | output | 1 | DLL is switched on |
| dll_locked | output | 1 | DLL on, reset and its lock window elapsed |
| dqs_n_en | output | 1 | Complementary data strobe in use |
| rdqs_en | output | 1 | Read data strobe in use |
| rdqs_n_en | output | 1 | Complementary read strobe in use |
| outputs_en | output | 1 | Data and strobe outputs enabled |
| drive_reduced | output | 1 | Reduced output drive selected |

## Verification
The hardest situation to reach is a READ that is waiting at the exact edge where the lock window closes. This must happen after a self-refresh exit as well as after an explicit DLL reset, because both paths reload the same window. The bench issues the reset or the exit and presents a READ in the very next cycle. It then counts the stalled cycles up to acceptance, so an off-by-one in either direction shows up. The inserted PRECHARGE ALL is reached by first switching the DLL off through an extended-register write and then raising the slow strap before an AUTO REFRESH.

// File: rtl/ddr2_guard_pkg.sv
package ddr2_guard_pkg;
   typedef enum logic [3:0] {
      CMD_NOP = 4'd0,
      CMD_ACT = 4'd1,
      CMD_RD  = 4'd2,
      CMD_WR  = 4'd3,
      CMD_PRE = 4'd4,
      CMD_REF = 4'd5,
      CMD_SRE = 4'd6,
      CMD_SRX = 4'd7,
      CMD_MRS = 4'd8
   } cmd_e;

   // Address bit positions decoded by the device.
   localparam int EB_DLL_OFF  = 0;
   localparam int EB_DRV_RED  = 1;
   localparam int EB_DQSN_OFF = 10;
   localparam int EB_RDQS_ON  = 11;
   localparam int EB_OUT_OFF  = 12;
   localparam int MB_DLL_RST  = 8;
   localparam int AB_ALL_BANK = 10;

   // Bank codes that select the mode register target.
   localparam int MR_MAIN = 0;
   localparam int MR_EXT  = 1;
endpackage

// File: rtl/ddr2_emr_decode.sv
module ddr2_emr_decode
   import ddr2_guard_pkg::*;
#(
   parameter int BA_W      = 3,
   parameter int DEV_WIDTH = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            iss_valid,
   input  logic [3:0]      iss_cmd,
   input  logic [BA_W-1:0] iss_ba,
   input  logic [4:0]      emr_bits,   // {out_off, rdqs_on, dqsn_off, drv_red, dll_off}
   output logic            dqs_n_en,
   output logic            rdqs_en,
   output logic            rdqs_n_en,
   output logic            outputs_en,
   output logic            drive_reduced
);
   logic drv_red_q, dqsn_off_q, rdqs_on_q, out_off_q;
   logic emr_wr;
   logic rdqs_eff;

   assign emr_wr = iss_valid && (iss_cmd == CMD_MRS) && (iss_ba == BA_W'(MR_EXT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_red_q  <= 1'b0;
         dqsn_off_q <= 1'b0;
         rdqs_on_q  <= 1'b0;
         out_off_q  <= 1'b0;
      end else if (emr_wr) begin
         drv_red_q  <= emr_bits[1];
         dqsn_off_q <= emr_bits[2];
         rdqs_on_q  <= emr_bits[3];
         out_off_q  <= emr_bits[4];
      end
   end

   generate
      if (DEV_WIDTH == 8) begin : g_rdqs_x8
         assign rdqs_eff = rdqs_on_q;
      end else begin : g_rdqs_none
         logic unused_rdqs;
         assign unused_rdqs = rdqs_on_q ^ emr_bits[0];
         assign rdqs_eff    = 1'b0;
      end
   endgenerate

   assign dqs_n_en      = !dqsn_off_q;
   assign rdqs_en       = rdqs_eff;
   assign rdqs_n_en     = rdqs_eff && !dqsn_off_q;
   assign outputs_en    = !out_off_q;
   assign drive_reduced = drv_red_q;
endmodule

// File: rtl/ddr2_dll_tracker.sv
module ddr2_dll_tracker
   import ddr2_guard_pkg::*;
#(
   parameter int BA_W        = 3,
   parameter int LOCK_CYCLES = 200
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            iss_valid,
   input  logic [3:0]      iss_cmd,
   input  logic [BA_W-1:0] iss_ba,
   input  logic            dll_off_bit,
   input  logic            dll_rst_bit,
   output logic            dll_on,
   output logic            dll_locked,
   output logic            read_block
);
   localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(LOCK_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             on_q, seen_q;
   logic             emr_wr, rst_wr, sre, srx;

   assign emr_wr = iss_valid && (iss_cmd == CMD_MRS) && (iss_ba == BA_W'(MR_EXT));
   assign rst_wr = iss_valid && (iss_cmd == CMD_MRS) && (iss_ba == BA_W'(MR_MAIN)) && dll_rst_bit;
   assign sre    = iss_valid && (iss_cmd == CMD_SRE);
   assign srx    = iss_valid && (iss_cmd == CMD_SRX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q   <= 1'b1;
         seen_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
         if (emr_wr) begin
            on_q <= !dll_off_bit;
            if (dll_off_bit || !on_q) seen_q <= 1'b0;
         end
         if (rst_wr) begin
            seen_q <= 1'b1;
            cnt_q  <= RELOAD;
         end
         if (sre) begin
            on_q   <= 1'b0;
            seen_q <= 1'b0;
         end
         if (srx) begin
            on_q   <= 1'b1;
            seen_q <= 1'b1;
            cnt_q  <= RELOAD;
         end
      end
   end

   assign dll_on     = on_q;
   assign dll_locked = on_q && seen_q && (cnt_q == '0);
   assign read_block = on_q && !dll_locked;
endmodule

// File: rtl/ddr2_cmd_gate.sv
module ddr2_cmd_gate
   import ddr2_guard_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int BA_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_mode,
   input  logic              dll_on,
   input  logic              read_block,
   input  logic              up_valid,
   input  logic [3:0]        up_cmd,
   input  logic [BA_W-1:0]   up_ba,
   input  logic [ADDR_W-1:0] up_addr,
   output logic              up_ready,
   output logic              dn_valid,
   output logic [3:0]        dn_cmd,
   output logic [BA_W-1:0]   dn_ba,
   output logic [ADDR_W-1:0] dn_addr
);
   localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << AB_ALL_BANK;

   logic pend_q;
   logic need_pall;

   assign up_ready = !pend_q && !(up_valid && (up_cmd == CMD_RD) && read_block);
   assign dn_valid = pend_q || (up_valid && up_ready);
   assign dn_cmd   = pend_q ? CMD_PRE : up_cmd;
   assign dn_ba    = pend_q ? '0 : up_ba;
   assign dn_addr  = pend_q ? ALL_BANKS : up_addr;

   assign need_pall = !pend_q && up_valid && up_ready && (up_cmd == CMD_REF)
                      && !dll_on && slow_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= need_pall;
   end
endmodule

// File: rtl/ddr2_dll_guard.sv
module ddr2_dll_guard
   import ddr2_guard_pkg::*;
#(
   parameter int ADDR_W      = 14,
   parameter int BA_W        = 3,
   parameter int LOCK_CYCLES = 200,
   parameter int DEV_WIDTH   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_mode,
   input  logic              up_valid,
   input  logic [3:0]        up_cmd,
   input  logic [BA_W-1:0]   up_ba,
   input  logic [ADDR_W-1:0] up_addr,
   output logic              up_ready,
   output logic              dn_valid,
   output logic [3:0]        dn_cmd,
   output logic [BA_W-1:0]   dn_ba,
   output logic [ADDR_W-1:0] dn_addr,
   output logic              dll_enabled,
   output logic              dll_locked,
   output logic              dqs_n_en,
   output logic              rdqs_en,
   output logic              rdqs_n_en,
   output logic              outputs_en,
   output logic              drive_reduced
);
   initial begin
      assert (ADDR_W >= EB_OUT_OFF + 1) else $error("ADDR_W too small for mode bits");
      assert (BA_W >= 1) else $error("BA_W must be at least 1");
      assert (LOCK_CYCLES >= 1) else $error("LOCK_CYCLES must be at least 1");
      assert (DEV_WIDTH == 4 || DEV_WIDTH == 8 || DEV_WIDTH == 16)
         else $error("DEV_WIDTH must be 4, 8 or 16");
   end

   logic read_block;
   logic [4:0] emr_bits;

   assign emr_bits = {dn_addr[EB_OUT_OFF], dn_addr[EB_RDQS_ON], dn_addr[EB_DQSN_OFF],
                      dn_addr[EB_DRV_RED], dn_addr[EB_DLL_OFF]};

   ddr2_cmd_gate #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode),
      .dll_on(dll_enabled), .read_block(read_block),
      .up_valid(up_valid), .up_cmd(up_cmd), .up_ba(up_ba), .up_addr(up_addr),
      .up_ready(up_ready), .dn_valid(dn_valid), .dn_cmd(dn_cmd),
      .dn_ba(dn_ba), .dn_addr(dn_addr)
   );

   ddr2_dll_tracker #(.BA_W(BA_W), .LOCK_CYCLES(LOCK_CYCLES)) u_track (
      .clk(clk), .rst_n(rst_n), .iss_valid(dn_valid), .iss_cmd(dn_cmd),
      .iss_ba(dn_ba), .dll_off_bit(dn_addr[EB_DLL_OFF]),
      .dll_rst_bit(dn_addr[MB_DLL_RST]),
      .dll_on(dll_enabled), .dll_locked(dll_locked), .read_block(read_block)
   );

   ddr2_emr_decode #(.BA_W(BA_W), .DEV_WIDTH(DEV_WIDTH)) u_emr (
      .clk(clk), .rst_n(rst_n), .iss_valid(dn_valid), .iss_cmd(dn_cmd),
      .iss_ba(dn_ba), .emr_bits(emr_bits),
      .dqs_n_en(dqs_n_en), .rdqs_en(rdqs_en), .rdqs_n_en(rdqs_n_en),
      .outputs_en(outputs_en), .drive_reduced(drive_reduced)
   );
endmodule

// File: rtl/ddr2_dll_guard_chk.sv
module ddr2_dll_guard_chk
   import ddr2_guard_pkg::*;
#(
   parameter int BA_W        = 3,
   parameter int LOCK_CYCLES = 200,
   parameter int DEV_WIDTH   = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            slow_mode,
   input logic            up_ready,
   input logic            dn_valid,
   input logic [3:0]      dn_cmd,
   input logic [BA_W-1:0] dn_ba,
   input logic            rst_bit,
   input logic            pall_bit,
   input logic            dll_enabled,
   input logic            dll_locked,
   input logic            dqs_n_en,
   input logic            rdqs_en,
   input logic            rdqs_n_en
);
   localparam int WIN_W = $clog2(LOCK_CYCLES + 1);

   logic [WIN_W-1:0] win_q;
   logic             restart;

   assign restart = dn_valid && ((dn_cmd == CMD_SRX) ||
                    ((dn_cmd == CMD_MRS) && (dn_ba == BA_W'(MR_MAIN)) && rst_bit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          win_q <= '0;
      else if (restart)                    win_q <= WIN_W'(1);
      else if (win_q != WIN_W'(LOCK_CYCLES)) win_q <= win_q + 1'b1;
   end

   // R3: a READ leaves only once the window since the last reset is full.
   p_read_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && dn_cmd == CMD_RD && dll_enabled) |-> (win_q == WIN_W'(LOCK_CYCLES)));

   // R3: with the DLL on, an issued READ implies the lock flag.
   p_read_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && dn_cmd == CMD_RD && dll_enabled) |-> dll_locked);

   // R4: leaving self refresh drops lock.
   p_srx_unlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (LOCK_CYCLES > 1 && dn_valid && dn_cmd == CMD_SRX) |=> (dll_enabled && !dll_locked));

   // R5: PRECHARGE ALL follows a slow, DLL-off refresh.
   p_pall_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && dn_cmd == CMD_REF && !dll_enabled && slow_mode)
      |=> (dn_valid && dn_cmd == CMD_PRE && pall_bit));

   // R6: scheduler stalled while the inserted command goes out.
   p_pall_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && dn_cmd == CMD_REF && !dll_enabled && slow_mode) |=> !up_ready);

   // R7: complementary read strobe needs both strobes on.
   p_rdqs_n_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rdqs_n_en |-> (rdqs_en && dqs_n_en));

   // R8: read strobe only for the x8 organisation.
   p_rdqs_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (DEV_WIDTH != 8) |-> (!rdqs_en && !rdqs_n_en));
endmodule

bind ddr2_dll_guard ddr2_dll_guard_chk #(
   .BA_W(BA_W), .LOCK_CYCLES(LOCK_CYCLES), .DEV_WIDTH(DEV_WIDTH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode), .up_ready(up_ready),
   .dn_valid(dn_valid), .dn_cmd(dn_cmd), .dn_ba(dn_ba),
   .rst_bit(dn_addr[8]), .pall_bit(dn_addr[10]),
   .dll_enabled(dll_enabled), .dll_locked(dll_locked),
   .dqs_n_en(dqs_n_en), .rdqs_en(rdqs_en), .rdqs_n_en(rdqs_n_en)
);

// File: tb/test_ddr2_dll_guard.sv
module test_ddr2_dll_guard;
   localparam int ADDR_W = 14;
   localparam int BA_W   = 3;
   localparam int LOCK   = 200;

   localparam logic [3:0] C_RD = 4'd2, C_PRE = 4'd4, C_REF = 4'd5,
                          C_SRE = 4'd6, C_SRX = 4'd7, C_MRS = 4'd8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slow_mode = 1'b0;
   logic up_valid = 1'b0;
   logic [3:0] up_cmd = '0;
   logic [BA_W-1:0] up_ba = '0;
   logic [ADDR_W-1:0] up_addr = '0;
   logic up_ready, dn_valid;
   logic [3:0] dn_cmd;
   logic [BA_W-1:0] dn_ba;
   logic [ADDR_W-1:0] dn_addr;
   logic dll_enabled, dll_locked, dqs_n_en, rdqs_en, rdqs_n_en, outputs_en, drive_reduced;
   logic x_ready, x_dv, x_en, x_lk, x_dqsn, x_rdqs, x_rdqsn, x_oe, x_drv;
   logic [3:0] x_cmd;
   logic [BA_W-1:0] x_ba;
   logic [ADDR_W-1:0] x_addr;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int stalls;
   logic last_dv;
   logic [3:0] last_cmd;

   always #10 clk = ~clk;

   ddr2_dll_guard #(.ADDR_W(ADDR_W), .BA_W(BA_W), .LOCK_CYCLES(LOCK), .DEV_WIDTH(8))
   i_ddr2_dll_guard (
      .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode), .up_valid(up_valid),
      .up_cmd(up_cmd), .up_ba(up_ba), .up_addr(up_addr), .up_ready(up_ready),
      .dn_valid(dn_valid), .dn_cmd(dn_cmd), .dn_ba(dn_ba), .dn_addr(dn_addr),
      .dll_enabled(dll_enabled), .dll_locked(dll_locked), .dqs_n_en(dqs_n_en),
      .rdqs_en(rdqs_en), .rdqs_n_en(rdqs_n_en), .outputs_en(outputs_en),
      .drive_reduced(drive_reduced));

   ddr2_dll_guard #(.ADDR_W(ADDR_W), .BA_W(BA_W), .LOCK_CYCLES(LOCK), .DEV_WIDTH(16))
   i_x16 (
      .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode), .up_valid(up_valid),
      .up_cmd(up_cmd), .up_ba(up_ba), .up_addr(up_addr), .up_ready(x_ready),
      .dn_valid(x_dv), .dn_cmd(x_cmd), .dn_ba(x_ba), .dn_addr(x_addr),
      .dll_enabled(x_en), .dll_locked(x_lk), .dqs_n_en(x_dqsn),
      .rdqs_en(x_rdqs), .rdqs_n_en(x_rdqsn), .outputs_en(x_oe),
      .drive_reduced(x_drv));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Present one command, wait for acceptance, count stalled cycles.
   task automatic send(input logic [3:0] cmd, input logic [BA_W-1:0] ba,
                       input logic [ADDR_W-1:0] addr);
      @(negedge clk);
      up_valid = 1'b1; up_cmd = cmd; up_ba = ba; up_addr = addr;
      stalls = 0;
      #1;
      while (!up_ready) begin
         if (dn_valid !== 1'b0) chk("R3 no issue while stalled", dn_valid, 0);
         stalls++;
         @(negedge clk); #1;
      end
      last_dv = dn_valid; last_cmd = dn_cmd;
      @(posedge clk); #1;
      up_valid = 1'b0; up_cmd = '0; up_addr = '0; up_ba = '0;
   endtask

   task automatic t_reset;
      chk("R1 dll_enabled", dll_enabled, 1);
      chk("R1 dll_locked", dll_locked, 0);
      chk("R1 dqs_n_en", dqs_n_en, 1);
      chk("R1 rdqs_en", rdqs_en, 0);
      chk("R1 rdqs_n_en", rdqs_n_en, 0);
      chk("R1 outputs_en", outputs_en, 1);
      chk("R1 drive_reduced", drive_reduced, 0);
      @(negedge clk);
      up_valid = 1'b1; up_cmd = C_RD;
      for (int i = 0; i < 5; i++) begin
         #1;
         chk("R1 read stalled before reset", {up_ready, dn_valid}, 0);
         @(negedge clk);
      end
      up_valid = 1'b0; up_cmd = '0;
   endtask

   task automatic t_lock;
      send(C_MRS, 0, ADDR_W'(1) << 8);
      chk("R3 reset issued", {last_dv, last_cmd}, {1'b1, C_MRS});
      chk("R3 unlocked after reset", dll_locked, 0);
      send(C_RD, 0, '0);
      chk("R3 stall count", stalls, LOCK - 1);
      chk("R3 read issued", {last_dv, last_cmd}, {1'b1, C_RD});
      chk("R3 locked", dll_locked, 1);
   endtask

   task automatic t_dll_off;
      send(C_MRS, 1, ADDR_W'(1));
      chk("R2 dll disabled", {dll_enabled, dll_locked}, 0);
      send(C_RD, 0, '0);
      chk("R10 read no stall", stalls, 0);
      chk("R10 read issued", {last_dv, last_cmd}, {1'b1, C_RD});
   endtask

   task automatic t_slow_ref;
      slow_mode = 1'b1;
      send(C_REF, 0, '0);
      #1;
      chk("R6 ready low in insert slot", up_ready, 0);
      chk("R5 inserted precharge", {dn_valid, dn_cmd}, {1'b1, C_PRE});
      chk("R5 all-bank bit", dn_addr[10], 1);
      chk("R5 bank zero", dn_ba, 0);
      @(posedge clk); #2;
      chk("R6 ready after insert", {up_ready, dn_valid}, 2'b10);
      slow_mode = 1'b0;
      send(C_REF, 0, '0);
      #1;
      chk("R6 no insert fast clock", {up_ready, dn_valid}, 2'b10);
   endtask

   task automatic t_reenable;
      send(C_MRS, 1, '0);
      chk("R2 re-enabled unlocked", {dll_enabled, dll_locked}, 2'b10);
      slow_mode = 1'b1;
      send(C_REF, 0, '0);
      #1;
      chk("R6 no insert dll on", {up_ready, dn_valid}, 2'b10);
      slow_mode = 1'b0;
      send(C_MRS, 0, ADDR_W'(1) << 8);
      send(C_RD, 0, '0);
      chk("R3 stall after re-enable", stalls, LOCK - 1);
   endtask

   task automatic t_selfref;
      send(C_SRE, 0, '0);
      chk("R4 self refresh entry", {dll_enabled, dll_locked}, 0);
      send(C_SRX, 0, '0);
      chk("R4 self refresh exit", {dll_enabled, dll_locked}, 2'b10);
      send(C_RD, 0, '0);
      chk("R4 stall after exit", stalls, LOCK - 1);
      chk("R4 read issued", {last_dv, last_cmd}, {1'b1, C_RD});
   endtask

   task automatic t_emr;
      send(C_MRS, 1, (ADDR_W'(1) << 10) | (ADDR_W'(1) << 11) | (ADDR_W'(1) << 1));
      chk("R7 dqs_n off", dqs_n_en, 0);
      chk("R7 rdqs on", rdqs_en, 1);
      chk("R7 rdqs_n off", rdqs_n_en, 0);
      chk("R9 drive reduced", drive_reduced, 1);
      chk("R9 outputs on", outputs_en, 1);
      chk("R8 x16 rdqs off", x_rdqs, 0);
      send(C_MRS, 1, (ADDR_W'(1) << 11) | (ADDR_W'(1) << 12));
      chk("R7 rdqs_n on", {dqs_n_en, rdqs_en, rdqs_n_en}, 3'b111);
      chk("R9 outputs off", outputs_en, 0);
      chk("R9 drive full", drive_reduced, 0);
      chk("R8 x16 rdqs pair off", {x_rdqs, x_rdqsn}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_lock();
      t_dll_off();
      t_slow_ref();
      t_reenable();
      t_selfref();
      t_emr();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule